// File: doc/BRIEF.md
# Cascadable Synchronous Binary Counter Stage

This block is one stage of a binary up-counter, `WIDTH` bits wide (4 by default), that is meant to be chained with others of its kind. Every change of state happens on a rising clock edge. An active-low clear forces the state to zero. An active-low load copies a parallel data word into the state. Counting advances the state by one, but only when two separate enables are both high.

A carry output signals that the stage sits at its all-ones value. Only the second enable, the chain enable, gates this carry. A wider counter is built by wiring each stage's carry into the chain enable of the next stage up.

Clear, load and count follow a fixed priority, and clear and load act only at the next edge. A user can therefore decode the state or the carry and feed it back into load or clear. Feeding the carry into load gives a sequence that starts at an offset. Decoding a chosen state into clear gives a sequence that ends early.

Top module: `cascade_counter`

## Requirements
- R1: When `clearN` is 0 at a rising edge, the state becomes 0, whatever the load and enable inputs are doing.
- R2: When `clearN` is 1 and `loadN` is 0 at a rising edge, the state becomes `loadData`, whatever the enables are doing.
- R3: When `clearN` and `loadN` are both 1 and `cntEn` and `chainEn` are both 1 at a rising edge, the state increases by one.
- R4: When `clearN` and `loadN` are both 1 and at least one of `cntEn` and `chainEn` is 0, the state is unchanged after the edge.
- R5: Counting up from the all-ones state (1111 at the default width) gives 0000.
- R6: `carryOut` is 1 exactly when the state is all ones and `chainEn` is 1. It does not depend on `cntEn`, and it follows `chainEn` combinationally within the same cycle.
- R7: Driving `clearN` or `loadN` low leaves `countQ` unchanged until the next rising edge.
- R8: When `carryOut` is inverted into `loadN` with `loadData` = 0110 and both enables high, the state runs 0110 through 1111 and then restarts at 0110.
- R9: When a decode of state 1101 drives `clearN` low and both enables are high, the state runs 0000 through 1101 and then returns to 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clearN | input | 1 | Synchronous clear, active low, highest priority |
| loadN | input | 1 | Synchronous parallel load, active low |
| cntEn | input | 1 | Count enable that does not affect the carry |
| chainEn | input | 1 | Count enable that also gates the carry; a lower stage's carry connects here |
| loadData | input | WIDTH | Value taken by a load |
| countQ | output | WIDTH | Present state |
| carryOut | output | 1 | High at all ones while `chainEn` is high |

## Verification
The state responds one rising edge after its inputs. The bench therefore drives inputs on the falling edge and compares `countQ` against its model on the following falling edge. Before that edge it confirms that the state has not yet moved, which covers R7. The carry is combinational, so it is compared 1 ns after each new input value, within the same cycle. In the offset runs, the bench closes the feedback loop from the carry or the state within the same low clock phase, before the edge that uses it.

// File: rtl/cascade_counter_pkg.sv
package cascade_counter_pkg;
  // Strobes passed from control to datapath; at most one is high.
  typedef struct packed {
    logic doClear;
    logic doLoad;
    logic doInc;
  } ctrStrobes_t;
endpackage

// File: rtl/cascade_counter_ctrl.sv
module cascade_counter_ctrl
  import cascade_counter_pkg::*;
(
  input  logic        clearN,
  input  logic        loadN,
  input  logic        cntEn,
  input  logic        chainEn,
  output ctrStrobes_t strobes
);
  logic clearReq;
  logic loadReq;
  logic incReq;

  // Priority: clear, then load, then increment.
  always_comb begin
    clearReq = ~clearN;
    loadReq  = clearN & ~loadN;
    incReq   = clearN & loadN & cntEn & chainEn;
  end

  always_comb begin
    strobes.doClear = clearReq;
    strobes.doLoad  = loadReq;
    strobes.doInc   = incReq;
  end
endmodule

// File: rtl/cascade_counter_dp.sv
module cascade_counter_dp
  import cascade_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  ctrStrobes_t      strobes,
  input  logic             chainEn,
  input  logic [WIDTH-1:0] loadData,
  output logic [WIDTH-1:0] countQ,
  output logic             carryOut
);
  localparam logic [WIDTH-1:0] ZERO = '0;

  logic [WIDTH:0]   lowOnes;   // lowOnes[i]: bits below i are all ones
  logic [WIDTH-1:0] incValue;
  logic [WIDTH-1:0] stateQ;
  logic [WIDTH-1:0] stateD;

  assign lowOnes[0] = 1'b1;

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_bit
      assign lowOnes[gi+1] = lowOnes[gi] & stateQ[gi];
      assign incValue[gi]  = stateQ[gi] ^ lowOnes[gi];
    end
  endgenerate

  always_comb begin
    stateD = stateQ;
    if (strobes.doClear)     stateD = ZERO;
    else if (strobes.doLoad) stateD = loadData;
    else if (strobes.doInc)  stateD = incValue;
  end

  always_ff @(posedge clk) begin
    stateQ <= stateD;
  end

  assign countQ   = stateQ;
  assign carryOut = chainEn & lowOnes[WIDTH];
endmodule

// File: rtl/cascade_counter.sv
module cascade_counter
  import cascade_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clearN,
  input  logic             loadN,
  input  logic             cntEn,
  input  logic             chainEn,
  input  logic [WIDTH-1:0] loadData,
  output logic [WIDTH-1:0] countQ,
  output logic             carryOut
);
  ctrStrobes_t strobes;

  cascade_counter_ctrl u_ctrl (
    .clearN  (clearN),
    .loadN   (loadN),
    .cntEn   (cntEn),
    .chainEn (chainEn),
    .strobes (strobes)
  );

  cascade_counter_dp #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .strobes  (strobes),
    .chainEn  (chainEn),
    .loadData (loadData),
    .countQ   (countQ),
    .carryOut (carryOut)
  );
endmodule

// File: rtl/cascade_counter_chk.sv
module cascade_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             clearN,
  input logic             loadN,
  input logic             cntEn,
  input logic             chainEn,
  input logic [WIDTH-1:0] loadData,
  input logic [WIDTH-1:0] countQ,
  input logic             carryOut
);
  localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};
  localparam logic [WIDTH-1:0] ALL1 = '1;

  // The state is known only after a first clear.
  logic started = 1'b0;
  always_ff @(posedge clk) begin
    if (!clearN) started <= 1'b1;
  end

  // R1
  clear_zero_chk: assert property (@(posedge clk) disable iff (!started)
    !clearN |=> countQ == '0);

  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (!started)
    (clearN && !loadN) |=> countQ == $past(loadData));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!started)
    (clearN && loadN && cntEn && chainEn) |=> countQ == $past(countQ) + ONE);

  // R4
  hold_state_chk: assert property (@(posedge clk) disable iff (!started)
    (clearN && loadN && !(cntEn && chainEn)) |=> $stable(countQ));

  // R5
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!started)
    (clearN && loadN && cntEn && chainEn && countQ == ALL1) |=> countQ == '0);

  // R6
  carry_cause_chk: assert property (@(posedge clk) disable iff (!started)
    carryOut |-> (chainEn && countQ == ALL1));

  // R6
  carry_present_chk: assert property (@(posedge clk) disable iff (!started)
    (chainEn && countQ == ALL1) |-> carryOut);
endmodule

bind cascade_counter cascade_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .clearN   (clearN),
  .loadN    (loadN),
  .cntEn    (cntEn),
  .chainEn  (chainEn),
  .loadData (loadData),
  .countQ   (countQ),
  .carryOut (carryOut)
);

// File: tb/tb_cascade_counter.sv
`timescale 1ns/1ps
module tb_cascade_counter;
  logic       clk = 1'b0;
  logic       clearN = 1'b1;
  logic       loadN = 1'b1;
  logic       cntEn = 1'b0;
  logic       chainEn = 1'b0;
  logic [3:0] loadData = 4'h0;
  logic [3:0] countQ;
  logic       carryOut;

  int compared = 0;
  int mismatched = 0;
  int refQ = -1;

  always #5 clk = ~clk;

  cascade_counter #(.WIDTH(4)) dut (
    .clk(clk), .clearN(clearN), .loadN(loadN), .cntEn(cntEn),
    .chainEn(chainEn), .loadData(loadData), .countQ(countQ), .carryOut(carryOut)
  );

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // fb: 0 plain, 1 carry fed to load (R8), 2 state 13 decoded to clear (R9)
  task automatic tick(input string req, input bit c, input bit l, input bit ce,
                      input bit ch, input logic [3:0] d, input int fb);
    clearN = c; loadN = l; cntEn = ce; chainEn = ch; loadData = d;
    #1;
    if (fb == 1) loadN = ~carryOut;
    if (fb == 2) clearN = (countQ != 4'd13);
    #1;
    if (refQ >= 0) begin
      chk("R6 carry", int'(carryOut), int'(chainEn && refQ == 15));
      chk("R7 no early change", int'(countQ), refQ);
    end
    @(posedge clk);
    if (!clearN)                refQ = 0;
    else if (!loadN)            refQ = int'(loadData);
    else if (cntEn && chainEn)  refQ = (refQ + 1) % 16;
    @(negedge clk);
    chk(req, int'(countQ), refQ);
  endtask

  initial begin
    #(200000 * 10);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    @(negedge clk);
    tick("R1 reset clear", 0, 1, 0, 0, 4'h0, 0);
    tick("R2 load 9", 1, 0, 1, 1, 4'h9, 0);
    tick("R1 clear beats load/count", 0, 0, 1, 1, 4'h5, 0);
    tick("R2 load beats count", 1, 0, 1, 1, 4'h3, 0);
    for (int i = 0; i < 4; i++) tick("R3 count", 1, 1, 1, 1, 4'h0, 0);
    tick("R4 hold cntEn low", 1, 1, 0, 1, 4'h0, 0);
    tick("R4 hold chainEn low", 1, 1, 1, 0, 4'h0, 0);
    tick("R4 hold both low", 1, 1, 0, 0, 4'hF, 0);
    tick("R2 load 14", 1, 0, 0, 0, 4'hE, 0);
    tick("R3 count to 15", 1, 1, 1, 1, 4'h0, 0);
    tick("R6 carry at 15 cntEn low", 1, 1, 0, 1, 4'h0, 0);
    tick("R6 carry gated chainEn low", 1, 1, 1, 0, 4'h0, 0);
    tick("R5 wrap to 0", 1, 1, 1, 1, 4'h0, 0);
    chk("R5 wrap value", int'(countQ), 0);
    tick("R2 load 12", 1, 0, 1, 1, 4'hC, 0);
    for (int i = 0; i < 14; i++) tick("R8 offset start", 1, 1, 1, 1, 4'h6, 1);
    chk("R8 restart seen", int'(countQ >= 4'd6), 1);
    tick("R1 clear", 0, 1, 1, 1, 4'h0, 0);
    for (int i = 0; i < 13; i++) tick("R9 offset end", 1, 1, 1, 1, 4'h0, 2);
    chk("R9 reached 13", int'(countQ), 13);
    tick("R9 return to 0", 1, 1, 1, 1, 4'h0, 2);
    chk("R9 zero after 13", int'(countQ), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule